// File: doc/BRIEF.md
# Serial MRAM Slave Model

This block is a synthesizable SPI slave that acts as a small byte-addressed magnetic RAM. It is placed on the far side of an SPI bus so that a controller design can be checked against a memory with realistic command handling. SPI runs in mode 0: SCLK idles low, both sides sample on the rising edge and shift on the falling edge, and every byte goes most significant bit first. The block samples SCLK, MOSI and chip select with its own system clock, so SCLK must stay well below that clock. With the bench settings each SCLK half period lasts 8 system clocks.

Each chip-select frame starts with a command byte. The block supports these commands: set and clear the write-enable latch, read the status byte, write the status byte, read data and write data. Read and write data take a 24-bit address, most significant byte first. Only the low address bits that select a location in the internal array are kept. The array has no erase step and no busy state. A write changes the addressed byte as soon as that byte has been received, at any address. The only thing that gates a write is the write-enable latch.

Top module: `spi_mram_model`

## Requirements
- R1: After reset the status byte reads 0x00, every memory byte reads 0x00, and MISO is low.
- R2: Command byte 0x06 sets the write-enable latch and command byte 0x04 clears it. The rest of either frame is ignored.
- R3: Command 0x05 returns the status byte on every following byte slot until chip select rises. The status layout is: bit 7 = write-lock flag, bits 3:2 = protect field, bit 1 = write-enable latch. Bits 6:4 and bit 0 always read 0.
- R4: Command 0x01 copies bit 7 and bits 3:2 of the next byte into the status byte, but only while the latch is set. With the latch clear, the status byte is left unchanged.
- R5: Command 0x03 is followed by three address bytes, most significant first. After them, MISO returns the addressed memory bytes MSB first. Address bits above the array index are ignored.
- R6: Command 0x02 with the latch set stores each data byte that follows the three address bytes.
- R7: Command 0x02 with the latch clear leaves the memory unchanged.
- R8: Within one frame the address increments after each data byte, both for read and for write. It wraps from the top of the array (0xFF by default) to 0.
- R9: When chip select rises at the end of a 0x02 or 0x01 frame, the write-enable latch is cleared.
- R10: Raising chip select in the middle of a byte discards that partial byte, does not store it, and makes the next frame start with a new command byte.
- R11: The protect field and the write-lock flag do not block data writes.
- R12: An unknown command byte makes the rest of its frame have no effect, and MISO stays low for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
Every pin passes through a two-stage synchronizer and an edge register. Because of this, a received byte reaches the command logic about four system clocks after its eighth rising SCLK edge. A new MISO bit appears about four clocks after each falling SCLK edge, and a store to the array lands one clock after the byte strobe.

The bench drives each SCLK half period for 8 system clocks. It samples MISO on the falling system-clock edge at which it raises SCLK, which is at least 8 clocks after the shift edge. It keeps chip select high for 16 clocks between frames. This gives every latch update, including the clear at the end of a frame, time to settle before the next frame reads it back. Expected bytes go into a queue before each byte slot. A monitor compares each received byte against that queue in order.

// File: rtl/spi_mram_pkg.sv
package spi_mram_pkg;

  localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OPC_WR_DISABLE = 8'h04;
  localparam logic [7:0] OPC_STAT_RD    = 8'h05;
  localparam logic [7:0] OPC_STAT_WR    = 8'h01;
  localparam logic [7:0] OPC_DATA_RD    = 8'h03;
  localparam logic [7:0] OPC_DATA_WR    = 8'h02;

  localparam int ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_DATA_RD,
    ST_DATA_WR,
    ST_STAT_RD,
    ST_STAT_WR,
    ST_DISCARD
  } mram_state_e;

endpackage

// File: rtl/spi_mram_sync.sv
module spi_mram_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_n [STAGES];

  always_comb begin
    stage_n[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_n[s] = stage_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_n[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_mram_shifter.sv
module spi_mram_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s_i,
  input  logic       cs_n_s_i,
  input  logic       mosi_s_i,
  input  logic [7:0] tx_byte_i,
  output logic       frame_act_o,
  output logic       frame_end_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       miso_o
);

  logic       sclk_d_q, cs_n_d_q;
  logic [2:0] bit_cnt_q, bit_cnt_n;
  logic [7:0] rx_q, rx_n;
  logic [7:0] tx_q, tx_n;
  logic       stb_q, stb_n;
  logic [7:0] byte_q, byte_n;
  logic       rise, fall;

  assign rise        = sclk_s_i & ~sclk_d_q;
  assign fall        = ~sclk_s_i & sclk_d_q;
  assign frame_act_o = ~cs_n_s_i;
  assign frame_end_o = cs_n_s_i & ~cs_n_d_q;

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    stb_n     = 1'b0;
    byte_n    = byte_q;
    if (!frame_act_o) begin
      bit_cnt_n = '0;
      rx_n      = '0;
      tx_n      = '0;
    end else begin
      if (rise) begin
        rx_n      = {rx_q[6:0], mosi_s_i};
        bit_cnt_n = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          stb_n  = 1'b1;
          byte_n = {rx_q[6:0], mosi_s_i};
        end
      end
      if (fall) begin
        if (bit_cnt_q == 3'd0) tx_n = tx_byte_i;
        else                   tx_n = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q  <= 1'b0;
      cs_n_d_q  <= 1'b1;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      stb_q     <= 1'b0;
      byte_q    <= '0;
    end else begin
      sclk_d_q  <= sclk_s_i;
      cs_n_d_q  <= cs_n_s_i;
      bit_cnt_q <= bit_cnt_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      stb_q     <= stb_n;
      byte_q    <= byte_n;
    end
  end

  assign byte_stb_o = stb_q;
  assign byte_o     = byte_q;
  assign miso_o     = tx_q[7];

  assert_idle_counter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act_o |=> (bit_cnt_q == 3'd0));
  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act_o |=> !miso_o);
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o |=> !byte_stb_o);

endmodule

// File: rtl/spi_mram_store.sv
module spi_mram_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  assert_store_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));

endmodule

// File: rtl/spi_mram_ctrl.sv
module spi_mram_ctrl
  import spi_mram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_act_i,
  input  logic          frame_end_i,
  input  logic          byte_stb_i,
  input  logic [7:0]    byte_i,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    tx_byte_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o
);

  localparam int CNT_W = $clog2(ADDR_BYTES);

  mram_state_e      state_q, state_n;
  logic [CNT_W-1:0] acnt_q, acnt_n;
  logic [AW-1:0]    addr_q, addr_n, addr_shift;
  logic             is_wr_q, is_wr_n;
  logic             wr_cmd_q, wr_cmd_n;
  logic             wel_q, wel_n;
  logic             lock_q, lock_n;
  logic [1:0]       prot_q, prot_n;
  logic [7:0]       status;

  if (AW > 8) begin : g_wide_addr
    assign addr_shift = {addr_q[AW-9:0], byte_i};
  end else begin : g_narrow_addr
    assign addr_shift = byte_i[AW-1:0];
  end

  assign status = {lock_q, 3'b000, prot_q, wel_q, 1'b0};

  always_comb begin
    state_n  = state_q;
    acnt_n   = acnt_q;
    addr_n   = addr_q;
    is_wr_n  = is_wr_q;
    wr_cmd_n = wr_cmd_q;
    wel_n    = wel_q;
    lock_n   = lock_q;
    prot_n   = prot_q;
    we_o     = 1'b0;
    if (!frame_act_i) begin
      state_n  = ST_OPCODE;
      acnt_n   = '0;
      wr_cmd_n = 1'b0;
      if (frame_end_i && wr_cmd_q) wel_n = 1'b0;
    end else if (byte_stb_i) begin
      unique case (state_q)
        ST_OPCODE: begin
          unique case (byte_i)
            OPC_WR_ENABLE:  begin wel_n = 1'b1; state_n = ST_DISCARD; end
            OPC_WR_DISABLE: begin wel_n = 1'b0; state_n = ST_DISCARD; end
            OPC_STAT_RD:    state_n = ST_STAT_RD;
            OPC_STAT_WR:    begin wr_cmd_n = 1'b1; state_n = ST_STAT_WR; end
            OPC_DATA_RD:    begin is_wr_n = 1'b0; state_n = ST_ADDR; end
            OPC_DATA_WR:    begin is_wr_n = 1'b1; wr_cmd_n = 1'b1; state_n = ST_ADDR; end
            default:        state_n = ST_DISCARD;
          endcase
        end
        ST_ADDR: begin
          addr_n = addr_shift;
          acnt_n = acnt_q + 1'b1;
          if (acnt_q == CNT_W'(ADDR_BYTES - 1))
            state_n = is_wr_q ? ST_DATA_WR : ST_DATA_RD;
        end
        ST_DATA_RD: addr_n = addr_q + 1'b1;
        ST_DATA_WR: begin
          we_o   = wel_q;
          addr_n = addr_q + 1'b1;
        end
        ST_STAT_WR: begin
          if (wel_q) begin
            lock_n = byte_i[7];
            prot_n = byte_i[3:2];
          end
          state_n = ST_DISCARD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STAT_RD: tx_byte_o = status;
      ST_DATA_RD: tx_byte_o = rd_data_i;
      default:    tx_byte_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OPCODE;
      acnt_q   <= '0;
      addr_q   <= '0;
      is_wr_q  <= 1'b0;
      wr_cmd_q <= 1'b0;
      wel_q    <= 1'b0;
      lock_q   <= 1'b0;
      prot_q   <= '0;
    end else begin
      state_q  <= state_n;
      acnt_q   <= acnt_n;
      addr_q   <= addr_n;
      is_wr_q  <= is_wr_n;
      wr_cmd_q <= wr_cmd_n;
      wel_q    <= wel_n;
      lock_q   <= lock_n;
      prot_q   <= prot_n;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = byte_i;

  assert_latch_set_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> ($past(byte_stb_i) && ($past(byte_i) == OPC_WR_ENABLE)));
  assert_latch_drop_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && wr_cmd_q) |=> !wel_q);
  assert_status_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> $stable({lock_q, prot_q}));
  assert_store_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DATA_WR) |-> !we_o);

endmodule

// File: rtl/spi_mram_model.sv
module spi_mram_model #(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);

  localparam int AW = $clog2(DEPTH);

  logic [2:0]    pins_s;
  logic          frame_act, frame_end, byte_stb;
  logic [7:0]    rx_byte, tx_byte, rd_data, wdata;
  logic          we;
  logic [AW-1:0] addr;

  spi_mram_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sclk, cs_n, mosi}),
    .sync_o  (pins_s)
  );

  spi_mram_shifter i_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s_i    (pins_s[2]),
    .cs_n_s_i    (pins_s[1]),
    .mosi_s_i    (pins_s[0]),
    .tx_byte_i   (tx_byte),
    .frame_act_o (frame_act),
    .frame_end_o (frame_end),
    .byte_stb_o  (byte_stb),
    .byte_o      (rx_byte),
    .miso_o      (miso)
  );

  spi_mram_ctrl #(.AW(AW)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_act_i (frame_act),
    .frame_end_i (frame_end),
    .byte_stb_i  (byte_stb),
    .byte_i      (rx_byte),
    .rd_data_i   (rd_data),
    .tx_byte_o   (tx_byte),
    .we_o        (we),
    .addr_o      (addr),
    .wdata_o     (wdata)
  );

  spi_mram_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rd_data)
  );

endmodule

// File: tb/test_spi_mram_model.sv
module test_spi_mram_model;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #10 clk = ~clk;

  spi_mram_model i_spi_mram_model (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0)
      check(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx;
    xfer_bits(tx, 8, rx);
  endtask

  task automatic recv_expect(input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer_bits(8'h00, 8, rx);
    act_q.push_back(rx);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_low(); send(op); cs_high();
  endtask

  task automatic status_expect(input int n, input logic [7:0] exp, input string tag);
    cs_low(); send(8'h05);
    for (int k = 0; k < n; k++) recv_expect(exp, tag);
    cs_high();
  endtask

  task automatic write_mem(input logic [23:0] a, input int n, input logic [23:0] d);
    cs_low(); send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) send(d[23 - 8*k -: 8]);
    cs_high();
  endtask

  task automatic read_expect(input logic [23:0] a, input int n, input logic [23:0] e, input string tag);
    cs_low(); send(8'h03); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) recv_expect(e[23 - 8*k -: 8], tag);
    cs_high();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check({7'd0, miso}, 8'h00, "R1 miso low");
    status_expect(1, 8'h00, "R1 status reset");
    read_expect(24'h000005, 1, 24'h000000, "R1 memory reset");
    // R7 write without latch
    write_mem(24'h000010, 1, 24'hAA0000);
    read_expect(24'h000010, 1, 24'h000000, "R7 blocked write");
    // R2 / R3 latch set, repeated status
    cmd(8'h06);
    status_expect(2, 8'h02, "R2 R3 latch set");
    // R6 / R8 / R9
    write_mem(24'h000010, 3, 24'h112233);
    status_expect(1, 8'h00, "R9 latch cleared after write");
    read_expect(24'h000010, 3, 24'h112233, "R6 R8 burst");
    // R8 wrap, R5 upper address bits ignored
    cmd(8'h06);
    write_mem(24'h1234FF, 2, 24'hA55A00);
    read_expect(24'h0000FF, 2, 24'hA55A00, "R8 wrap read");
    read_expect(24'hABCD00, 1, 24'h5A0000, "R5 upper bits ignored");
    // R2 disable
    cmd(8'h06);
    cmd(8'h04);
    status_expect(1, 8'h00, "R2 latch cleared");
    write_mem(24'h000020, 1, 24'h990000);
    read_expect(24'h000020, 1, 24'h000000, "R7 after disable");
    // R4 status write
    cmd(8'h06);
    cs_low(); send(8'h01); send(8'hFF); cs_high();
    status_expect(3, 8'h8C, "R4 R9 status written");
    cs_low(); send(8'h01); send(8'h00); cs_high();
    status_expect(1, 8'h8C, "R4 blocked status write");
    // R11 protect bits do not gate writes
    cmd(8'h06);
    write_mem(24'h000040, 1, 24'h770000);
    read_expect(24'h000040, 1, 24'h770000, "R11 write with protect set");
    // R10 abort mid data byte
    cmd(8'h06);
    cs_low(); send(8'h02); send(8'h00); send(8'h00); send(8'h50);
    xfer_bits(8'hFF, 4, junk); cs_high();
    read_expect(24'h000050, 1, 24'h000000, "R10 partial byte dropped");
    status_expect(1, 8'h8C, "R10 R9 latch cleared on abort");
    cs_low(); xfer_bits(8'h05, 5, junk); cs_high();
    status_expect(1, 8'h8C, "R10 decoder restarts");
    // R12 unknown command
    cs_low(); send(8'hAB);
    recv_expect(8'h00, "R12 unknown command");
    recv_expect(8'h00, "R12 unknown command");
    cs_high();
    status_expect(1, 8'h8C, "R12 no side effect");
    read_expect(24'h000011, 2, 24'h223300, "R6 data retained");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule